// File: doc/BRIEF.md
# Multi-CPU private region address router

This block sits in front of a 4 KB window of per-CPU private peripherals that several processors share. Each access carries a byte address, a write flag, write data and a 2-bit identifier of the CPU making it. The router looks only at the low 12 bits of the address. It sends the access to one of three places: a small snoop-control register group that it holds itself, the interrupt interface of one CPU, or one of eight timer units (a timer and a watchdog for each of four CPUs).

Both the interrupt interfaces and the timers can be reached in two ways. One is an alias window that always maps to the CPU making the request. The other is a set of banked windows, one per CPU, in which the CPU index comes from the address. For the timers, that CPU index is doubled, and address bit 5 adds one to pick the watchdog instead of the timer. Targets are selected in the same cycle as the request. The router returns a response one cycle later, carrying either the data read from the target or the local register, or an error for an offset that maps to nothing.

Top module: `prv_window_router`

## Requirements
- R1: Address bits above bit 11 are ignored. Two accesses whose low 12 bits match produce the same routing and response.
- R2: Offset 0x000 is a control register that resets to 0. A write stores wdata bit 0 only, and a read returns that bit in bit 0 with all other bits zero.
- R3: A read of offset 0x004 returns 0x000000F3. Reads of 0x008 and 0x00C return 0. A write to 0x00C is accepted without error and changes nothing.
- R4: Offsets 0x100–0x1FF assert gif_sel in the same cycle, with gif_cpu = req_cpu, gif_off = address bits 7:0, and gif_write and gif_wdata copied from the request.
- R5: Offsets 0x200–0x5FF assert gif_sel with gif_cpu = (offset − 0x200) >> 8, so 0x2xx gives CPU 0 and 0x5xx gives CPU 3.
- R6: Offsets 0x600–0x6FF assert tmr_sel in the same cycle, with tmr_unit = 2·req_cpu + address bit 5 and tmr_reg = address bits 3:0. Write flag and data are copied.
- R7: Offsets 0x700–0xAFF assert tmr_sel with tmr_unit = 2·((offset − 0x700) >> 8) + address bit 5.
- R8: These accesses are illegal: any offset below 0x100 other than 0x000/0x004/0x008/0x00C, a write to 0x004 or 0x008, and any offset of 0xB00 or higher. An illegal access asserts no target select, returns rsp_err = 1 and rsp_rdata = 0 for one cycle, and does not change the control register.
- R9: rsp_valid is high in the cycle after each request and only then. A legal read returns the target's read data as sampled in the request cycle. A legal write returns 0 with rsp_err = 0.
- R10: While rst is high, and in the first cycle after it, rsp_valid and rsp_err are 0. No target select is asserted unless req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 11:0 decoded |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | ID of the requesting CPU |
| gif_sel | output | 1 | Interrupt interface selected |
| gif_write | output | 1 | Write flag to interrupt interface |
| gif_cpu | output | 2 | Interrupt interface CPU index |
| gif_off | output | 8 | Register offset inside the interface |
| gif_wdata | output | DATA_W | Write data to interrupt interface |
| gif_rdata | input | DATA_W | Read data from selected interface |
| tmr_sel | output | 1 | Timer unit selected |
| tmr_write | output | 1 | Write flag to timer unit |
| tmr_unit | output | 3 | Timer unit index (2·CPU + watchdog) |
| tmr_reg | output | 4 | Register inside the timer unit |
| tmr_wdata | output | DATA_W | Write data to timer unit |
| tmr_rdata | input | DATA_W | Read data from selected timer unit |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Illegal offset response |
| rsp_rdata | output | DATA_W | Response read data |

## Verification
The target select, index, offset and write fields are combinational. They are due in the same cycle as the request, so the bench samples them shortly after driving the inputs and before the next rising edge. The response (valid, error, data) passes through one register stage. It is sampled just after the following edge, with the bench expecting the target read data it drove during the request cycle. One cycle later, with the request removed, the bench checks that rsp_valid has dropped again. Control register effects are checked by a later read of offset 0x000, which compares against a bench model that only legal writes update.

// File: rtl/prv_router_pkg.sv
package prv_router_pkg;

    localparam int NCPU       = 4;
    localparam int CPU_W      = $clog2(NCPU);
    localparam int UNIT_W     = CPU_W + 1;
    localparam int OFF_W      = 12;
    localparam int SUB_W      = 8;
    localparam int TREG_W     = 4;
    localparam int PAGE_W     = OFF_W - SUB_W;
    localparam int WDOG_BIT   = 5;

    // region boundaries, in 256-byte pages of the window
    localparam logic [PAGE_W-1:0] PG_GIF_ALIAS = PAGE_W'(1);
    localparam logic [PAGE_W-1:0] PG_GIF_BANK  = PAGE_W'(2);
    localparam logic [PAGE_W-1:0] PG_TMR_ALIAS = PAGE_W'(2 + NCPU);
    localparam logic [PAGE_W-1:0] PG_TMR_BANK  = PAGE_W'(3 + NCPU);
    localparam logic [PAGE_W-1:0] PG_END       = PAGE_W'(3 + 2 * NCPU);

    // local register group
    localparam logic [SUB_W-1:0] LR_CTRL  = 8'h00;
    localparam logic [SUB_W-1:0] LR_CONF  = 8'h04;
    localparam logic [SUB_W-1:0] LR_STAT  = 8'h08;
    localparam logic [SUB_W-1:0] LR_FLUSH = 8'h0C;
    localparam logic [7:0]       CONF_VALUE = 8'hF3;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOC  = 2'd1,
        TGT_GIF  = 2'd2,
        TGT_TMR  = 2'd3
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic                legal;
        logic [CPU_W-1:0]    cpu;
        logic [UNIT_W-1:0]   unit;
        logic [SUB_W-1:0]    sub;
    } route_t;

    // CPU index of a banked page, counted from the first bank page
    function automatic logic [CPU_W-1:0] bank_cpu(
        input logic [PAGE_W-1:0] page,
        input logic [PAGE_W-1:0] first
    );
        logic [PAGE_W-1:0] d;
        d = page - first;
        return d[CPU_W-1:0];
    endfunction

    // which local register offsets accept a given access kind
    function automatic logic loc_legal(
        input logic [SUB_W-1:0] sub,
        input logic             wr
    );
        logic ok;
        case (sub)
            LR_CTRL, LR_FLUSH: ok = 1'b1;
            LR_CONF, LR_STAT:  ok = !wr;
            default:           ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/prv_decode.sv
module prv_decode
    import prv_router_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output route_t            route
);

    logic [OFF_W-1:0]  off;
    logic [PAGE_W-1:0] page;
    logic [CPU_W-1:0]  tmr_cpu;
    logic              unused_hi;

    assign off       = req_addr[OFF_W-1:0];
    assign page      = off[OFF_W-1:SUB_W];
    assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];

    always_comb begin
        tmr_cpu     = '0;
        route.tgt   = TGT_NONE;
        route.legal = 1'b0;
        route.cpu   = '0;
        route.unit  = '0;
        route.sub   = off[SUB_W-1:0];
        if (page == '0) begin
            route.tgt   = TGT_LOC;
            route.legal = loc_legal(off[SUB_W-1:0], req_write);
        end else if (page < PG_TMR_ALIAS) begin
            route.tgt   = TGT_GIF;
            route.legal = 1'b1;
            route.cpu   = (page == PG_GIF_ALIAS) ? req_cpu
                                                 : bank_cpu(page, PG_GIF_BANK);
        end else if (page < PG_END) begin
            tmr_cpu     = (page == PG_TMR_ALIAS) ? req_cpu
                                                 : bank_cpu(page, PG_TMR_BANK);
            route.tgt   = TGT_TMR;
            route.legal = 1'b1;
            route.cpu   = tmr_cpu;
            route.unit  = {tmr_cpu, off[WDOG_BIT]};
        end
        if (!route.legal) begin
            route.tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/prv_local_regs.sv
module prv_local_regs
    import prv_router_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SUB_W-1:0]  sub,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ctl_q
);

    logic unused_wd;
    assign unused_wd = ^wdata[DATA_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= 1'b0;
        end else if (wr_en && sub == LR_CTRL) begin
            ctl_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sub)
            LR_CTRL: rdata[0]   = ctl_q;
            LR_CONF: rdata[7:0] = CONF_VALUE;
            default: rdata      = '0;
        endcase
    end

endmodule

// File: rtl/prv_rsp_stage.sv
module prv_rsp_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              legal,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && legal) ? rdata_in : '0;
        end
    end

endmodule

// File: rtl/prv_window_router.sv
module prv_window_router
    import prv_router_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_cpu,
    output logic              gif_sel,
    output logic              gif_write,
    output logic [1:0]        gif_cpu,
    output logic [7:0]        gif_off,
    output logic [DATA_W-1:0] gif_wdata,
    input  logic [DATA_W-1:0] gif_rdata,
    output logic              tmr_sel,
    output logic              tmr_write,
    output logic [2:0]        tmr_unit,
    output logic [3:0]        tmr_reg,
    output logic [DATA_W-1:0] tmr_wdata,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    route_t            route;
    logic [DATA_W-1:0] loc_rdata;
    logic [DATA_W-1:0] rd_mux;
    logic              loc_wr;
    logic              ctl_q;

    prv_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_cpu   (req_cpu),
        .route     (route)
    );

    assign loc_wr = req_valid && req_write && route.tgt == TGT_LOC;

    prv_local_regs #(.DATA_W(DATA_W)) u_local (
        .clk   (clk),
        .rst   (rst),
        .wr_en (loc_wr),
        .sub   (route.sub),
        .wdata (req_wdata),
        .rdata (loc_rdata),
        .ctl_q (ctl_q)
    );

    // target side: combinational, same cycle as the request
    assign gif_sel   = req_valid && route.tgt == TGT_GIF;
    assign gif_write = req_write;
    assign gif_cpu   = route.cpu;
    assign gif_off   = route.sub;
    assign gif_wdata = req_wdata;

    assign tmr_sel   = req_valid && route.tgt == TGT_TMR;
    assign tmr_write = req_write;
    assign tmr_unit  = route.unit;
    assign tmr_reg   = route.sub[TREG_W-1:0];
    assign tmr_wdata = req_wdata;

    always_comb begin
        rd_mux = '0;
        if (!req_write) begin
            case (route.tgt)
                TGT_LOC: rd_mux = loc_rdata;
                TGT_GIF: rd_mux = gif_rdata;
                TGT_TMR: rd_mux = tmr_rdata;
                default: rd_mux = '0;
            endcase
        end
    end

    prv_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .legal     (route.legal),
        .rdata_in  (rd_mux),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/prv_window_router_checker.sv
module prv_window_router_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_cpu,
    input logic              gif_sel,
    input logic [1:0]        gif_cpu,
    input logic              tmr_sel,
    input logic [2:0]        tmr_unit,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ctl_q
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid) && !$past(rst)) else $error("rsp without req"); // R9
    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("req without rsp"); // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid && rsp_rdata == '0) else $error("err data"); // R8
    AST_HIGH_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:8] >= 4'hB) |-> !gif_sel && !tmr_sel) else $error("high sel"); // R8
    AST_HIGH_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:8] >= 4'hB) |=> rsp_err) else $error("high no err"); // R8
    AST_TARGET_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (gif_sel || tmr_sel) |=> rsp_valid && !rsp_err) else $error("target err"); // R9
    AST_GIF_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:8] == 4'h1) |-> gif_sel && gif_cpu == req_cpu) else $error("gif alias"); // R4
    AST_TMR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:8] == 4'h6) |-> tmr_sel && tmr_unit == {req_cpu, req_addr[5]}) else $error("tmr alias"); // R6
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_addr[11:0] == 12'h000) |=> $stable(ctl_q)) else $error("ctl changed"); // R2
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !gif_sel && !tmr_sel) else $error("idle sel"); // R10

endmodule

bind prv_window_router prv_window_router_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .gif_sel   (gif_sel),
    .gif_cpu   (gif_cpu),
    .tmr_sel   (tmr_sel),
    .tmr_unit  (tmr_unit),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ctl_q     (ctl_q)
);

// File: tb/prv_window_router_bench.sv
`timescale 1ns/1ps
module prv_window_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_cpu;
    logic        gif_sel, gif_write, tmr_sel, tmr_write;
    logic [1:0]  gif_cpu;
    logic [7:0]  gif_off;
    logic [2:0]  tmr_unit;
    logic [3:0]  tmr_reg;
    logic [31:0] gif_wdata, tmr_wdata, gif_rdata, tmr_rdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic model_ctl = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    prv_window_router u_prv_window_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .gif_sel(gif_sel), .gif_write(gif_write), .gif_cpu(gif_cpu),
        .gif_off(gif_off), .gif_wdata(gif_wdata), .gif_rdata(gif_rdata),
        .tmr_sel(tmr_sel), .tmr_write(tmr_write), .tmr_unit(tmr_unit),
        .tmr_reg(tmr_reg), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // region tag from the requirement text
    function automatic string region_tag(input logic [11:0] off);
        if (off < 12'h001) return "R2";
        if (off < 12'h100) return "R3";
        if (off < 12'h200) return "R4";
        if (off < 12'h600) return "R5";
        if (off < 12'h700) return "R6";
        if (off < 12'hB00) return "R7";
        return "R8";
    endfunction

    function automatic bit is_legal(input logic [11:0] off, input logic wr);
        if (off >= 12'hB00) return 1'b0;
        if (off >= 12'h100) return 1'b1;
        if (off == 12'h000 || off == 12'h00C) return 1'b1;
        if (off == 12'h004 || off == 12'h008) return !wr;
        return 1'b0;
    endfunction

    task automatic access(input logic wr, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [1:0] cpu);
        logic [11:0] off;
        string tag;
        bit legal, exp_gif, exp_tmr;
        logic [1:0] exp_cpu;
        logic [31:0] exp_rd, gr, tr;
        off = addr[11:0];
        tag = is_legal(off, wr) ? region_tag(off) : "R8";
        legal = is_legal(off, wr);
        exp_gif = legal && off >= 12'h100 && off < 12'h600;
        exp_tmr = legal && off >= 12'h600 && off < 12'hB00;
        gr = $urandom;
        tr = $urandom;
        exp_cpu = 2'd0;
        if (off >= 12'h100 && off < 12'h200) exp_cpu = cpu;
        else if (off >= 12'h200 && off < 12'h600) exp_cpu = 2'((off - 12'h200) >> 8);
        else if (off >= 12'h600 && off < 12'h700) exp_cpu = cpu;
        else if (off >= 12'h700 && off < 12'hB00) exp_cpu = 2'((off - 12'h700) >> 8);
        exp_rd = 32'h0;
        if (legal && !wr) begin
            if (off == 12'h000) exp_rd = {31'h0, model_ctl};
            else if (off == 12'h004) exp_rd = 32'h0000_00F3;
            else if (exp_gif) exp_rd = gr;
            else if (exp_tmr) exp_rd = tr;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = wd; req_cpu = cpu; gif_rdata = gr; tmr_rdata = tr;
        #2;
        chk(tag, "gif_sel", 32'(gif_sel), 32'(exp_gif));
        chk(tag, "tmr_sel", 32'(tmr_sel), 32'(exp_tmr));
        if (exp_gif) begin
            chk(tag, "gif_cpu", 32'(gif_cpu), 32'(exp_cpu));
            chk(tag, "gif_off", 32'(gif_off), 32'(off[7:0]));
            chk(tag, "gif_write", 32'(gif_write), 32'(wr));
            chk(tag, "gif_wdata", gif_wdata, wd);
        end
        if (exp_tmr) begin
            chk(tag, "tmr_unit", 32'(tmr_unit), 32'({exp_cpu, off[5]}));
            chk(tag, "tmr_reg", 32'(tmr_reg), 32'(off[3:0]));
            chk(tag, "tmr_write", 32'(tmr_write), 32'(wr));
            chk(tag, "tmr_wdata", tmr_wdata, wd);
        end
        @(negedge clk);
        #1;
        chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(legal ? "R9" : "R8", "rsp_err", 32'(rsp_err), 32'(!legal));
        chk(legal ? tag : "R8", "rsp_rdata", rsp_rdata, exp_rd);
        if (legal && wr && off == 12'h000) model_ctl = wd[0];
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R9", "rsp_valid drop", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_cpu = '0; gif_rdata = '0; tmr_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R10", "rsp_err in reset", 32'(rsp_err), 32'd0);
        rst = 1'b0;
        #1;
        chk("R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R10", "gif_sel idle", 32'(gif_sel), 32'd0);

        // directed corners
        access(1'b0, 32'h0000_0000, 32'h0, 2'd0);          // R2 reset value
        access(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 2'd1);  // R2 bit 0 only
        access(1'b0, 32'h0000_0000, 32'h0, 2'd2);
        access(1'b1, 32'h0000_0004, 32'h0, 2'd0);          // R8 write to config
        access(1'b1, 32'h0000_0008, 32'h0, 2'd0);          // R8 write to status
        access(1'b0, 32'h0000_0004, 32'h0, 2'd3);          // R3
        access(1'b0, 32'h0000_0008, 32'h0, 2'd3);          // R3
        access(1'b1, 32'h0000_000C, 32'h0, 2'd0);          // R3 flush write
        access(1'b0, 32'h0000_000C, 32'h0, 2'd0);
        access(1'b0, 32'h0000_0000, 32'h0, 2'd0);          // R2 still 1
        access(1'b1, 32'h0000_0002, 32'h0, 2'd0);          // R8 unaligned
        access(1'b0, 32'h0000_0000, 32'h0, 2'd0);
        access(1'b0, 32'h1234_5000, 32'h0, 2'd0);          // R1 alias of 0x000
        access(1'b1, 32'hABCD_E000, 32'h0, 2'd0);          // R1 write via high bits
        access(1'b0, 32'h0000_0000, 32'h0, 2'd0);
        access(1'b0, 32'h0000_01FF, 32'h0, 2'd2);          // R4 top of alias
        access(1'b0, 32'h0000_0200, 32'h0, 2'd3);          // R5 bank 0
        access(1'b1, 32'h0000_05FF, 32'h77, 2'd0);         // R5 bank 3
        access(1'b0, 32'h0000_0620, 32'h0, 2'd3);          // R6 watchdog
        access(1'b1, 32'h0000_06DF, 32'h55, 2'd1);         // R6 timer
        access(1'b0, 32'h0000_0AFF, 32'h0, 2'd0);          // R7 last legal
        access(1'b0, 32'h0000_0B00, 32'h0, 2'd0);          // R8 first illegal
        access(1'b1, 32'h0000_0FFC, 32'h1, 2'd0);          // R8 no ctl change
        access(1'b0, 32'h0000_0000, 32'h0, 2'd0);
        access(1'b0, 32'hFFFF_F700, 32'h0, 2'd2);          // R1 / R7

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [11:0] o;
            int cls;
            a   = $urandom;
            cls = $urandom_range(0, 7);
            case (cls)
                0: o = {8'h00, 2'b00, 2'($urandom_range(0, 3)), 2'b00};
                1: o = {4'h0, 8'($urandom)};
                2: o = {4'h1, 8'($urandom)};
                3: o = {4'($urandom_range(2, 5)), 8'($urandom)};
                4: o = {4'h6, 8'($urandom)};
                5: o = {4'($urandom_range(7, 10)), 8'($urandom)};
                6: o = {4'($urandom_range(11, 15)), 8'($urandom)};
                default: o = 12'($urandom);
            endcase
            a[11:0] = o;
            access(1'($urandom), a, $urandom, 2'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule